// File: doc/BRIEF.md
# Euler-Step Differential Equation Engine

This block integrates a second-order differential equation by running forward-Euler steps in hardware until an exit test succeeds. The caller places the starting position x, the state values y and u, the step size dx and the limit a on the operand inputs. A one-cycle start pulse, given while the engine is idle, loads them. The engine then runs its loop body as many times as needed. After the last pass it raises done for one cycle and presents the final y on its result output.

Each pass takes exactly four control steps and uses a fixed binding. Four multiplier instances work in steps 1 and 2. One ALU instance handles the add, the two subtractions and the position update. A second ALU instance performs the signed compare. Every result that crosses a step boundary sits in a register. All values are signed fixed-point words of a parameterised width and fraction length, and all arithmetic wraps.

Top module: `ode_step_engine`

## Requirements
- R1: While reset is high and in the first cycle after it, done is 0 and y_out is 0.
- R2: A start pulse is taken only when the engine is idle, and that is the only time the five operand inputs are loaded. A start pulse or operand change during a run has no effect on the result of that run and produces no extra done pulse.
- R3: One pass computes x' = x + dx, y' = y + (u·dx) and u' = u − (3x)·(u·dx) − (3y)·dx, all from the values held before the pass. A product p·q is the full signed product shifted right arithmetically by FRAC_W bits and cut to DATA_W bits. 3x and 3y are the DATA_W-bit wrapped triples. All sums and differences wrap modulo 2^DATA_W.
- R4: The exit flag of a pass is the signed comparison x' < a. The engine runs passes until the first pass whose flag is 1, and then reports the y' of that pass.
- R5: Every pass lasts exactly four clock cycles. If start is accepted at edge k and N passes are run, done is high in the cycle that follows edge k + 4N.
- R6: At least one pass is always run, even when the loaded x is already below a.
- R7: done is high for exactly one cycle per run. y_out changes only at the edge that raises done and otherwise holds its value, including through the next run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load operands and begin a run; used only when idle |
| x_in | input | DATA_W | Initial position x |
| y_in | input | DATA_W | Initial y |
| u_in | input | DATA_W | Initial u |
| dx_in | input | DATA_W | Step size dx |
| a_in | input | DATA_W | Exit limit a |
| done | output | 1 | One-cycle completion pulse |
| y_out | output | DATA_W | Final y of the latest completed run |

## Verification
The hardest situation to reach from the ports is a long run whose u and y wrap repeatedly. In such a run a wrong operand choice or a wrong truncation in any multiplier would change the result. The stimulus gets there by loading x well above a with a negative dx. This forces a dozen or more passes with growing values, and the bench compares the wrapped result against its own restatement of the arithmetic. A second start pulse with different operands is injected in the middle of such a run. It must leave both the result and the count of done pulses unchanged.

// File: rtl/ode_pkg.sv
package ode_pkg;

  // Controller states: idle, the four control steps of one pass, completion.
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_S1   = 3'd1,
    ST_S2   = 3'd2,
    ST_S3   = 3'd3,
    ST_S4   = 3'd4,
    ST_DONE = 3'd5
  } ode_state_e;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_LT  = 2'd2
  } alu_op_e;

  // Resource allocation fixed by the schedule.
  localparam int N_MUL   = 4;
  localparam int N_ALU   = 2;
  localparam int N_STEPS = 4;

endpackage

// File: rtl/ode_mul.sv
// Fixed-point multiplier instance with its own result register.
module ode_mul #(
  parameter int W = 16,
  parameter int F = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic signed [W-1:0] a,
  input  logic signed [W-1:0] b,
  output logic signed [W-1:0] p
);

  localparam int PW = 2 * W;

  function automatic logic signed [W-1:0] fx_mul(input logic signed [W-1:0] op_a,
                                                 input logic signed [W-1:0] op_b);
    logic signed [PW-1:0] ea;
    logic signed [PW-1:0] eb;
    logic signed [PW-1:0] full;
    ea   = PW'(op_a);
    eb   = PW'(op_b);
    full = ea * eb;
    return W'(full >>> F);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      p <= '0;
    end else if (en) begin
      p <= fx_mul(a, b);
    end
  end

endmodule

// File: rtl/ode_alu.sv
// Combinational ALU instance: add, subtract, signed less-than.
module ode_alu
  import ode_pkg::*;
#(
  parameter int W = 16
) (
  input  alu_op_e             op,
  input  logic signed [W-1:0] a,
  input  logic signed [W-1:0] b,
  output logic signed [W-1:0] y
);

  function automatic logic signed [W-1:0] alu_eval(input alu_op_e o,
                                                   input logic signed [W-1:0] l,
                                                   input logic signed [W-1:0] r);
    logic signed [W-1:0] res;
    case (o)
      ALU_ADD: res = l + r;
      ALU_SUB: res = l - r;
      ALU_LT:  res = {{(W-1){1'b0}}, (l < r)};
      default: res = '0;
    endcase
    return res;
  endfunction

  always_comb begin
    y = alu_eval(op, a, b);
  end

endmodule

// File: rtl/ode_ctrl.sv
// Control FSM: idle, four control steps per pass, one-cycle completion state.
module ode_ctrl
  import ode_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       exit_flag,
  output ode_state_e state
);

  ode_state_e state_nx;

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE: if (start) state_nx = ST_S1;
      ST_S1:   state_nx = ST_S2;
      ST_S2:   state_nx = ST_S3;
      ST_S3:   state_nx = ST_S4;
      ST_S4:   state_nx = exit_flag ? ST_DONE : ST_S1;
      ST_DONE: state_nx = ST_IDLE;
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
    end else begin
      state <= state_nx;
    end
  end

endmodule

// File: rtl/ode_datapath.sv
// Operand registers, operation-to-resource binding and step-crossing registers.
module ode_datapath
  import ode_pkg::*;
#(
  parameter int W = 16,
  parameter int F = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  ode_state_e          state,
  input  logic                load,
  input  logic signed [W-1:0] x_in,
  input  logic signed [W-1:0] y_in,
  input  logic signed [W-1:0] u_in,
  input  logic signed [W-1:0] dx_in,
  input  logic signed [W-1:0] a_in,
  output logic                exit_flag,
  output logic                commit,
  output logic signed [W-1:0] lim_q,
  output logic signed [W-1:0] y_out
);

  // Constant 3 as a fixed-point multiplier operand.
  localparam logic signed [W-1:0] K3 = W'(3 * (2 ** F));

  // Architectural state
  logic signed [W-1:0] x_q, y_q, u_q, dx_q;
  // Values that cross control-step boundaries
  logic signed [W-1:0] x_nx, y_nx, t_q;

  // Multiplier resources
  logic [N_MUL-1:0]    mul_en;
  logic signed [W-1:0] mul_a [N_MUL];
  logic signed [W-1:0] mul_b [N_MUL];
  logic signed [W-1:0] mul_p [N_MUL];

  // ALU resources: 0 = add/sub, 1 = compare
  alu_op_e             alu_op [N_ALU];
  logic signed [W-1:0] alu_a  [N_ALU];
  logic signed [W-1:0] alu_b  [N_ALU];
  logic signed [W-1:0] alu_y  [N_ALU];

  logic in_s1, in_s2, in_s3, in_s4;
  assign in_s1 = (state == ST_S1);
  assign in_s2 = (state == ST_S2);
  assign in_s3 = (state == ST_S3);
  assign in_s4 = (state == ST_S4);
  assign commit = in_s4;

  // Multiplier binding:
  //   step 1: m0 = 3*x, m1 = u*dx, m2 = 3*y, m3 = u*dx
  //   step 2: m0 = (3x)*(u dx), m2 = (3y)*dx
  always_comb begin
    for (int i = 0; i < N_MUL; i++) begin
      mul_a[i] = '0;
      mul_b[i] = '0;
    end
    mul_en = '0;
    if (in_s1) begin
      mul_en   = '1;
      mul_a[0] = K3;   mul_b[0] = x_q;
      mul_a[1] = u_q;  mul_b[1] = dx_q;
      mul_a[2] = K3;   mul_b[2] = y_q;
      mul_a[3] = u_q;  mul_b[3] = dx_q;
    end else if (in_s2) begin
      mul_en[0] = 1'b1;
      mul_en[2] = 1'b1;
      mul_a[0]  = mul_p[0]; mul_b[0] = mul_p[1];
      mul_a[2]  = mul_p[2]; mul_b[2] = dx_q;
    end
  end

  for (genvar g = 0; g < N_MUL; g++) begin : g_mul
    ode_mul #(.W(W), .F(F)) u_mul (
      .clk (clk),
      .rst (rst),
      .en  (mul_en[g]),
      .a   (mul_a[g]),
      .b   (mul_b[g]),
      .p   (mul_p[g])
    );
  end

  // ALU binding:
  //   ALU0 step 1: x + dx     step 2: y + (u dx)
  //        step 3: u - m0     step 4: t - m2
  //   ALU1 step 2: x' < a
  always_comb begin
    alu_op[0] = ALU_ADD; alu_a[0] = '0; alu_b[0] = '0;
    alu_op[1] = ALU_LT;  alu_a[1] = x_nx; alu_b[1] = lim_q;
    case (state)
      ST_S1: begin alu_op[0] = ALU_ADD; alu_a[0] = x_q; alu_b[0] = dx_q;     end
      ST_S2: begin alu_op[0] = ALU_ADD; alu_a[0] = y_q; alu_b[0] = mul_p[3]; end
      ST_S3: begin alu_op[0] = ALU_SUB; alu_a[0] = u_q; alu_b[0] = mul_p[0]; end
      ST_S4: begin alu_op[0] = ALU_SUB; alu_a[0] = t_q; alu_b[0] = mul_p[2]; end
      default: ;
    endcase
  end

  for (genvar g = 0; g < N_ALU; g++) begin : g_alu
    ode_alu #(.W(W)) u_alu (
      .op (alu_op[g]),
      .a  (alu_a[g]),
      .b  (alu_b[g]),
      .y  (alu_y[g])
    );
  end

  // Register updates
  always_ff @(posedge clk) begin
    if (rst) begin
      x_q       <= '0;
      y_q       <= '0;
      u_q       <= '0;
      dx_q      <= '0;
      lim_q     <= '0;
      x_nx      <= '0;
      y_nx      <= '0;
      t_q       <= '0;
      exit_flag <= 1'b0;
      y_out     <= '0;
    end else begin
      if (load) begin
        x_q   <= x_in;
        y_q   <= y_in;
        u_q   <= u_in;
        dx_q  <= dx_in;
        lim_q <= a_in;
      end
      if (in_s1) x_nx <= alu_y[0];
      if (in_s2) begin
        y_nx      <= alu_y[0];
        exit_flag <= (alu_y[1] != '0);
      end
      if (in_s3) t_q <= alu_y[0];
      if (in_s4) begin
        x_q <= x_nx;
        y_q <= y_nx;
        u_q <= alu_y[0];
        if (exit_flag) y_out <= y_nx;
      end
    end
  end

endmodule

// File: rtl/ode_step_engine.sv
// Top: forward-Euler iteration engine.
module ode_step_engine
  import ode_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int FRAC_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic signed [DATA_W-1:0] x_in,
  input  logic signed [DATA_W-1:0] y_in,
  input  logic signed [DATA_W-1:0] u_in,
  input  logic signed [DATA_W-1:0] dx_in,
  input  logic signed [DATA_W-1:0] a_in,
  output logic                     done,
  output logic signed [DATA_W-1:0] y_out
);

  ode_state_e          state;
  logic                exit_flag;
  logic                commit;
  logic                load;
  logic                idle;
  logic [N_STEPS-1:0]  step_vec;
  logic signed [DATA_W-1:0] lim_q;

  // Named events for the checker
  assign idle     = (state == ST_IDLE);
  assign load     = idle & start;
  assign done     = (state == ST_DONE);
  assign step_vec = {state == ST_S4, state == ST_S3, state == ST_S2, state == ST_S1};

  ode_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .exit_flag (exit_flag),
    .state     (state)
  );

  ode_datapath #(.W(DATA_W), .F(FRAC_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .state     (state),
    .load      (load),
    .x_in      (x_in),
    .y_in      (y_in),
    .u_in      (u_in),
    .dx_in     (dx_in),
    .a_in      (a_in),
    .exit_flag (exit_flag),
    .commit    (commit),
    .lim_q     (lim_q),
    .y_out     (y_out)
  );

endmodule

// File: rtl/ode_step_engine_chk.sv
module ode_step_engine_chk #(
  parameter int W = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                done,
  input logic                load,
  input logic                exit_flag,
  input logic                commit,
  input logic [3:0]          step_vec,
  input logic signed [W-1:0] lim_q,
  input logic signed [W-1:0] y_out
);

  AST_STEP_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({step_vec, done})); // R5

  AST_S1_TO_S2: assert property (@(posedge clk) disable iff (rst)
    step_vec[0] |=> step_vec[1]); // R5

  AST_S2_TO_S3: assert property (@(posedge clk) disable iff (rst)
    step_vec[1] |=> step_vec[2]); // R5

  AST_S3_TO_S4: assert property (@(posedge clk) disable iff (rst)
    step_vec[2] |=> step_vec[3]); // R5

  AST_S4_NEXT: assert property (@(posedge clk) disable iff (rst)
    step_vec[3] |=> (step_vec[0] || done)); // R4

  AST_EXIT_ENDS: assert property (@(posedge clk) disable iff (rst)
    (commit && exit_flag) |=> done); // R4

  AST_DONE_FROM_S4: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(step_vec[3])); // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7

  AST_YOUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$stable(y_out) |-> done); // R7

  AST_LOAD_ONLY: assert property (@(posedge clk) disable iff (rst)
    !$stable(lim_q) |-> $past(load)); // R2

  AST_RUN_ENTRY: assert property (@(posedge clk) disable iff (rst)
    load |=> step_vec[0]); // R6

endmodule

bind ode_step_engine ode_step_engine_chk #(.W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .done      (done),
  .load      (load),
  .exit_flag (exit_flag),
  .commit    (commit),
  .step_vec  (step_vec),
  .lim_q     (lim_q),
  .y_out     (y_out)
);

// File: tb/ode_step_engine_bench.sv
`timescale 1ns/1ps
module ode_step_engine_bench;

  localparam int W = 16;
  localparam int F = 8;
  localparam int ONE = 1 << F;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic signed [W-1:0] x_in = '0, y_in = '0, u_in = '0, dx_in = '0, a_in = '0;
  logic done;
  logic signed [W-1:0] y_out;

  always #2 clk = ~clk;

  ode_step_engine #(.DATA_W(W), .FRAC_W(F)) u_ode_step_engine (
    .clk(clk), .rst(rst), .start(start),
    .x_in(x_in), .y_in(y_in), .u_in(u_in), .dx_in(dx_in), .a_in(a_in),
    .done(done), .y_out(y_out)
  );

  typedef struct {
    logic signed [W-1:0] y;
    int                  lat;
    int                  t0;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  int   cyc = 0;
  int   done_cnt = 0;
  bit   prev_done = 1'b0;
  bit   finished = 1'b0;
  logic signed [W-1:0] last_y = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // Independent restatement of the arithmetic
  function automatic logic signed [W-1:0] fxm(input logic signed [W-1:0] a,
                                              input logic signed [W-1:0] b);
    longint p;
    p = longint'(a) * longint'(b);
    p = p >>> F;
    return p[W-1:0];
  endfunction

  function automatic logic signed [W-1:0] trip(input logic signed [W-1:0] v);
    longint t;
    t = longint'(v) + longint'(v) + longint'(v);
    return t[W-1:0];
  endfunction

  task automatic model(input logic signed [W-1:0] x0, y0, u0, dx, a,
                       output logic signed [W-1:0] yres, output int n);
    logic signed [W-1:0] x, y, u, xn, yn, un, ud;
    x = x0; y = y0; u = u0; n = 0;
    forever begin
      ud = fxm(u, dx);
      xn = x + dx;
      yn = y + ud;
      un = u - fxm(trip(x), ud) - fxm(trip(y), dx);
      x = xn; y = yn; u = un;
      n++;
      if (xn < a || n >= 2000) break;
    end
    yres = y;
  endtask

  // Driver: pushes the expected result, then pulses start
  task automatic run_case(input logic signed [W-1:0] x0, y0, u0, dx, a,
                          input bit disturb);
    exp_t e;
    int   n;
    model(x0, y0, u0, dx, a, e.y, n);
    e.lat = 4 * n + 1;
    @(negedge clk);
    x_in = x0; y_in = y0; u_in = u0; dx_in = dx; a_in = a;
    start = 1'b1;
    e.t0 = cyc;
    exp_q.push_back(e);
    @(negedge clk);
    start = 1'b0;
    x_in = 16'sh1234; y_in = -16'sd77; u_in = 16'sh0a0a; dx_in = 16'sd3; a_in = 16'sh7fff;
    if (disturb) begin
      @(negedge clk);
      // R7: y_out still holds the previous result during the run
      check(y_out == last_y, "R7 hold", y_out, last_y);
      start = 1'b1;
      x_in = -16'sd5; a_in = 16'sh7fff; dx_in = 16'sd1;
      @(negedge clk);
      start = 1'b0;
    end
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  // Monitor: pops expected items when done appears
  always @(negedge clk) begin
    if (!rst) begin
      if (done) begin
        exp_t e;
        done_cnt++;
        check(!prev_done, "R7 pulse", prev_done, 0);
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 extra done", 1, 0);
        end else begin
          e = exp_q.pop_front();
          check(y_out == e.y, "R3/R4 result", y_out, e.y);
          check(cyc - e.t0 == e.lat, "R5 latency", cyc - e.t0, e.lat);
          last_y = y_out;
        end
      end
      prev_done = done;
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int dc;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(done == 1'b0, "R1 done", done, 0);
    check(y_out == '0, "R1 y_out", y_out, 0);
    rst = 1'b0;
    @(negedge clk);
    check(done == 1'b0 && y_out == '0, "R1 after release", y_out, 0);

    // R6, R4: exit after the first pass (x already below a, dx = 0)
    run_case(16'sd0, 16'sd128, 16'sd64, 16'sd0, ONE, 1'b0);
    // R6: x + dx below a immediately
    run_case(16'sd0, -16'sd300, 16'sd256, 16'sd128, ONE, 1'b0);
    // R3, R4: many passes with wrap (x from 4.0 down to below 1.0)
    run_case(16'sd1024, 16'sd256, 16'sd128, -16'sd64, ONE, 1'b0);
    // R4: signed compare with negative limit
    run_case(-16'sd256, 16'sd40, -16'sd90, -16'sd128, -16'sd512, 1'b0);
    // R3: mixed signs, fractional step
    run_case(16'sd700, -16'sd513, 16'sd333, -16'sd37, 16'sd100, 1'b0);
    // R2: second start and operand changes during a long run are ignored
    dc = done_cnt;
    run_case(16'sd2048, 16'sd17, -16'sd200, -16'sd96, 16'sd0, 1'b1);
    repeat (20) @(negedge clk);
    check(done_cnt == dc + 1, "R2 done count", done_cnt, dc + 1);
    check(y_out == last_y, "R7 hold idle", y_out, last_y);
    // R3: large magnitudes
    run_case(16'sd32000, 16'sd30000, -16'sd29000, -16'sd4000, 16'sd10000, 1'b0);
    // R7: hold across a following run
    run_case(16'sd300, 16'sd5, 16'sd9, -16'sd50, 16'sd120, 1'b1);

    repeat (5) @(negedge clk);
    finish_run();
  end

endmodule